// File: doc/BRIEF.md
# Marked Posted-Write Drain Monitor

This block sits next to the two posted-write queues of a bridge, one per direction. When its active-low mark input falls, it records how many write entries each queue holds at that moment. It then holds an active-low pending output low until every recorded entry has left its queue. Writes that arrive after the mark are not recorded. An agent that has to forward an event can therefore wait on the pending output, and only forward the event once every write issued before that event has been delivered.

The mark input is asynchronous and passes through a synchronizer. The snapshot is taken a fixed two clock edges after the mark is first sampled low, and the pending output changes on that same edge. Before that edge the pending output does not yet reflect the new mark. A configuration input can also make the block withhold permission to post new writes for as long as the synchronized mark stays low.

Top module: `wr_flush_tracker`

## Requirements
- R1: While rst_ni is low, pend_no is 1 and post_ok_o is 1, whatever the mark and configuration inputs are.
- R2: A falling mark_ni first sampled low at clock edge k drives pend_no to 0 after edge k+2, and pend_no is still 1 after edge k+1.
- R3: At edge k+2 each queue's tag count is loaded with that queue's occupancy input minus one if that queue pops on the same edge. Pushes made after the mark do not add to the tag count.
- R4: After the load, each pop of a queue lowers its tag count by one. pend_no returns to 1 after the edge on which the last tagged entry of the second queue pops, and it stays 0 while either queue still has tagged entries.
- R5: If both tag counts load as zero, pend_no is 0 for exactly one cycle and then returns to 1.
- R6: A new falling mark while entries are still tagged reloads both tag counts from the current occupancy, with the same two-edge timing as R2.
- R7: A rising mark, or a mark held low after draining, leaves pend_no unchanged. Only falling edges cause tagging.
- R8: With dis_post_i = 1, post_ok_o is 0 from edge k+2 after the mark is first sampled low, until edge m+2 after the mark is first sampled high again. With dis_post_i = 0, post_ok_o stays 1.
- R9: A tag count never wraps below zero. Pops of untagged entries after a queue's tags are exhausted do not hold pend_no low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mark_ni | input | 1 | Asynchronous mark request, active low |
| dis_post_i | input | 1 | Configuration: block posting while the mark is low |
| up_push_i | input | 1 | Upstream queue accepted a write this cycle |
| up_pop_i | input | 1 | Upstream queue delivered its head entry this cycle |
| up_cnt_i | input | CNT_W | Upstream queue occupancy before this cycle's push and pop |
| dn_push_i | input | 1 | Downstream queue accepted a write this cycle |
| dn_pop_i | input | 1 | Downstream queue delivered its head entry this cycle |
| dn_cnt_i | input | CNT_W | Downstream queue occupancy before this cycle's push and pop |
| pend_no | output | 1 | Low while tagged write data remains buffered |
| post_ok_o | output | 1 | High when new writes may be posted |

## Verification
Two events can land on the same clock edge: the snapshot load and a pop of the queue being recorded. The bench asserts a pop exactly on edge k+2. It expects the tag count to be one short of the occupancy, so pend_no must rise one pop sooner than it would if the occupancy were loaded unchanged. A second collision, a fresh mark fall arriving while earlier tags are still draining, is provoked after extra pushes. It is judged by whether pend_no stays low for the new, larger occupancy rather than the old remainder.

// File: rtl/wft_pkg.sv
package wft_pkg;
  localparam int unsigned NUM_BUF = 2;
  localparam int unsigned BUF_UP  = 0;
  localparam int unsigned BUF_DN  = 1;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/wft_sync.sv
module wft_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_ni,
  output logic level_no,
  output logic fall_o
);
  logic [STAGES:0] q;

  for (genvar g = 0; g <= STAGES; g++) begin : g_ff
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    q[g] <= 1'b1;
      else if (g == 0) q[g] <= async_ni;
      else            q[g] <= q[(g == 0) ? 0 : g-1];
    end
  end

  assign level_no = q[STAGES-1];
  assign fall_o   = q[STAGES] & ~q[STAGES-1];

  AST_FALL_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o); // R7
endmodule

// File: rtl/wft_tag_cnt.sv
module wft_tag_cnt #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             pop_i,
  input  logic [CNT_W-1:0] occ_i,
  output logic             busy_nxt_o
);
  logic [CNT_W-1:0] left_q, left_d, load_val;

  always_comb begin
    load_val = (pop_i && occ_i != '0) ? occ_i - CNT_W'(1) : occ_i;
    left_d   = left_q;
    if (load_i)                    left_d = load_val;
    else if (pop_i && left_q != '0) left_d = left_q - CNT_W'(1); // saturate at zero
  end

  assign busy_nxt_o = |left_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) left_q <= '0;
    else         left_q <= left_d;
  end

  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (left_q <= $past(left_q))); // R9
  AST_SNAPSHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !pop_i) |=> (left_q == $past(occ_i))); // R3
endmodule

// File: rtl/wft_gate.sv
module wft_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dis_i,
  input  logic mark_lvl_ni,
  output logic post_ok_o
);
  logic ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ok_q <= 1'b1;
    else         ok_q <= ~(dis_i & ~mark_lvl_ni);
  end

  assign post_ok_o = ok_q;

  AST_GATE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dis_i |=> post_ok_o); // R8
endmodule

// File: rtl/wr_flush_tracker.sv
module wr_flush_tracker
  import wft_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mark_ni,
  input  logic             dis_post_i,
  input  logic             up_push_i,
  input  logic             up_pop_i,
  input  logic [CNT_W-1:0] up_cnt_i,
  input  logic             dn_push_i,
  input  logic             dn_pop_i,
  input  logic [CNT_W-1:0] dn_cnt_i,
  output logic             pend_no,
  output logic             post_ok_o
);
  logic mark_lvl_n, mark_fall;
  logic [NUM_BUF-1:0]            pop_v, busy_nxt;
  logic [NUM_BUF-1:0][CNT_W-1:0] occ_v;
  logic pend_q, pend_d;

  wft_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .async_ni (mark_ni),
    .level_no (mark_lvl_n),
    .fall_o   (mark_fall)
  );

  assign pop_v[BUF_UP] = up_pop_i;
  assign pop_v[BUF_DN] = dn_pop_i;
  assign occ_v[BUF_UP] = up_cnt_i;
  assign occ_v[BUF_DN] = dn_cnt_i;

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
    wft_tag_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (mark_fall),
      .pop_i      (pop_v[b]),
      .occ_i      (occ_v[b]),
      .busy_nxt_o (busy_nxt[b])
    );
  end

  // set on snapshot, cleared on the edge that drains the last tagged entry
  assign pend_d = mark_fall | (pend_q & (|busy_nxt));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

  assign pend_no = ~pend_q;

  wft_gate u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dis_i       (dis_post_i),
    .mark_lvl_ni (mark_lvl_n),
    .post_ok_o   (post_ok_o)
  );

  AST_ROSE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pend_no) |-> $past(mark_fall)); // R2
  AST_FALL_ASSERTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mark_fall |=> !pend_no); // R6
  AST_EMPTY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mark_fall && up_cnt_i == '0 && dn_cnt_i == '0) |=> !pend_no ##1 pend_no); // R5
  AST_NO_PUSH_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !post_ok_o |-> !(up_push_i || dn_push_i)); // R8
endmodule

// File: tb/wr_flush_tracker_bench.sv
`timescale 1ns/1ps
module wr_flush_tracker_bench;
  localparam int CW = 5;
  localparam int NV = 6;
  // {up occupancy, dn occupancy, up pop period, dn pop period}
  localparam logic [15:0] VEC [NV] = '{
    16'h3211, 16'h0011, 16'h5113, 16'h1621, 16'h4422, 16'h7011
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_ni, mark_ni, dis_post_i;
  logic up_push_i, up_pop_i, dn_push_i, dn_pop_i;
  logic [CW-1:0] up_cnt_i, dn_cnt_i;
  logic pend_no, post_ok_o;

  int n_chk = 0, n_bad = 0;
  int occ_u, occ_d, tag_u, tag_d;
  bit dis_m;

  wr_flush_tracker #(.CNT_W(CW)) u_wr_flush_tracker (
    .clk_i(clk), .rst_ni(rst_ni), .mark_ni(mark_ni), .dis_post_i(dis_post_i),
    .up_push_i(up_push_i), .up_pop_i(up_pop_i), .up_cnt_i(up_cnt_i),
    .dn_push_i(dn_push_i), .dn_pop_i(dn_pop_i), .dn_cnt_i(dn_cnt_i),
    .pend_no(pend_no), .post_ok_o(post_ok_o)
  );

  task automatic chk(input logic got, input logic exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0b exp=%0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic drive_occ();
    up_cnt_i = CW'(occ_u);
    dn_cnt_i = CW'(occ_d);
  endtask

  // drive strobes at a negedge, cross one posedge, update the model
  task automatic step(input bit pu, input bit pd, input bit psu);
    up_pop_i = pu; dn_pop_i = pd; up_push_i = psu; drive_occ();
    @(negedge clk);
    if (pu) begin occ_u--; if (tag_u > 0) tag_u--; end
    if (pd) begin occ_d--; if (tag_d > 0) tag_d--; end
    if (psu) occ_u++;
    up_pop_i = 0; dn_pop_i = 0; up_push_i = 0; drive_occ();
  endtask

  task automatic mark_and_load(input string tg);
    mark_ni = 1'b0;
    @(negedge clk); chk(pend_no, 1'b1, {"R2 edge k ", tg});
    @(negedge clk); chk(pend_no, 1'b1, {"R2 edge k+1 ", tg});
    chk(post_ok_o, 1'b1, {"R8 edge k+1 ", tg});
  endtask

  task automatic release_mark();
    mark_ni = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(post_ok_o, !dis_m, "R8 still held m+1");
    @(negedge clk);
    chk(post_ok_o, 1'b1, "R8 released m+2");
    chk(pend_no, 1'b1, "R7 rise no effect");
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_ni = 0; mark_ni = 0; dis_post_i = 1; dis_m = 1;
    up_push_i = 0; up_pop_i = 0; dn_push_i = 0; dn_pop_i = 0;
    occ_u = 0; occ_d = 0; drive_occ();
    repeat (3) @(negedge clk);
    chk(pend_no, 1'b1, "R1 pend in reset");
    chk(post_ok_o, 1'b1, "R1 post_ok in reset");
    mark_ni = 1;
    @(negedge clk);
    rst_ni = 1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      int pu, pd, cyc;
      occ_u = int'(VEC[i][15:12]); occ_d = int'(VEC[i][11:8]);
      pu = int'(VEC[i][7:4]); pd = int'(VEC[i][3:0]);
      dis_m = (i % 2) == 0; dis_post_i = dis_m;
      drive_occ();
      mark_and_load("vec");
      @(negedge clk);
      chk(pend_no, 1'b0, "R2 edge k+2");
      chk(post_ok_o, !dis_m, "R8 edge k+2");
      tag_u = occ_u; tag_d = occ_d; cyc = 0;
      do begin
        step((tag_u > 0) && (cyc % pu == 0), (tag_d > 0) && (cyc % pd == 0), 1'b0);
        cyc++;
        chk(pend_no, (tag_u | tag_d) == 0, "R4 drain (R5 when empty)");
        chk(post_ok_o, !dis_m, "R8 hold");
      end while ((tag_u | tag_d) != 0 && cyc < 64);
      step(1'b0, 1'b0, 1'b0);
      chk(pend_no, 1'b1, "R7 low level no retrigger");
      release_mark();
    end

    // R9 / R3: pushes after mark are untagged, extra pops do not wrap
    dis_m = 0; dis_post_i = 0;
    occ_u = 1; occ_d = 3; drive_occ();
    mark_and_load("r9");
    @(negedge clk); chk(pend_no, 1'b0, "R2 r9 load");
    tag_u = 1; tag_d = 3;
    step(1, 0, 1); chk(pend_no, 1'b0, "R3 push untagged");
    step(1, 1, 0); chk(pend_no, 1'b0, "R9 untagged pop");
    step(0, 1, 0); chk(pend_no, 1'b0, "R4 dn left");
    step(0, 1, 0); chk(pend_no, 1'b1, "R9 no wrap drain");
    release_mark();

    // R3: pop on the load edge reduces the snapshot
    occ_u = 2; occ_d = 0; drive_occ();
    mark_and_load("r3");
    step(1, 0, 0); chk(pend_no, 1'b0, "R3 load with pop");
    step(0, 0, 0); chk(pend_no, 1'b0, "R3 one left");
    step(1, 0, 0); chk(pend_no, 1'b1, "R3 drained early");
    release_mark();

    // R6: re-mark while draining reloads from current occupancy
    occ_u = 3; occ_d = 2; drive_occ();
    mark_and_load("r6");
    @(negedge clk); chk(pend_no, 1'b0, "R2 r6 load");
    tag_u = 3; tag_d = 2;
    step(1, 1, 0); chk(pend_no, 1'b0, "R4 partial");
    mark_ni = 1'b1;
    for (int j = 0; j < 3; j++) begin
      step(0, 0, 1); chk(pend_no, 1'b0, "R7 rise while pending");
    end
    mark_ni = 1'b0;
    @(negedge clk); chk(pend_no, 1'b0, "R6 wait k");
    @(negedge clk); chk(pend_no, 1'b0, "R6 wait k+1");
    @(negedge clk);
    tag_u = occ_u; tag_d = occ_d;
    chk(pend_no, 1'b0, "R6 reloaded");
    while ((tag_u | tag_d) != 0) begin
      step(tag_u > 0, tag_d > 0, 1'b0);
      chk(pend_no, (tag_u | tag_d) == 0, "R6 drain new snapshot");
    end
    release_mark();

    summary();
  end
endmodule